// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block holds the digital counters of an integer-N frequency synthesizer. A reference path divides a stream of reference-clock events by a 15-bit ratio and emits one pulse per divided period. An LO path counts the output periods of a dual-modulus prescaler. A 7-bit swallow counter and an 11-bit main counter drive the prescaler's modulus-control line, so that each divided LO period spans exactly P·B+A input LO cycles. The two pulse outputs go to a phase-frequency detector.

The prescaler pair is either 16/17 or 32/33, picked by one select input. For simulation, and for designs that oversample the LO, a behavioural digital model of the prescaler can be instantiated inside the block. When it is left out, the LO event input carries the prescaler's output edges directly. All ratios are shadowed: a value presented at the inputs is taken only at the end of the current output period, so no period is ever cut short or stretched by a reprogramming. While the loop enable is low, every counter rests at its start value and the shadow registers follow the inputs.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With the loop enabled, `ref_pulse` is high for one cycle in the clock cycle after every R-th `ref_tick`, where R is the value of `r_ratio`; R = 0 behaves as R = 1.
- R2: With the prescaler model in place, `lo_pulse` is high for one cycle in the clock cycle after the tick that completes P·B+A `lo_tick` events, where A is `a_count` and B is `b_count` with A ≤ B; B = 0 behaves as B = 1.
- R3: `pair_sel` = 0 selects P = 16 (moduli 16 and 17); `pair_sel` = 1 selects P = 32 (moduli 32 and 33).
- R4: Within each LO output period, `mod_ctl` is high (prescaler divides by P+1) for the first A prescaler periods and low for the remaining ones, so A·(P+1) of the period's LO ticks fall while `mod_ctl` is high. In the cycle in which `lo_pulse` is high, `mod_ctl` equals (A ≠ 0) for the newly loaded A.
- R5: `cfg_err` is high exactly when the A value in use exceeds the B value in use. In that case `mod_ctl` stays high for all B prescaler periods and the period lasts B·(P+1) ticks.
- R6: Changes to `r_ratio`, `a_count`, `b_count` and `pair_sel` made during an output period do not alter that period. They take effect from the next period of the same divider.
- R7: While `pll_en` is low, no pulse is produced, the counters rest at their start values, and the shadow registers load the inputs every cycle. The first period after `pll_en` rises is a full period.
- R8: After reset, `ref_pulse`, `lo_pulse`, `mod_ctl` and `cfg_err` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all events are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_en | input | 1 | Loop enable; low holds all counters at their start values |
| ref_tick | input | 1 | One reference-clock event per cycle in which it is high |
| lo_tick | input | 1 | One LO event (model variant) or prescaler output edge (external variant) |
| r_ratio | input | 15 | Reference division ratio R |
| a_count | input | 7 | Swallow count A |
| b_count | input | 11 | Main count B |
| pair_sel | input | 1 | Modulus pair select: 0 gives 16/17, 1 gives 32/33 |
| ref_pulse | output | 1 | One-cycle pulse per divided reference period |
| lo_pulse | output | 1 | One-cycle pulse per divided LO period |
| mod_ctl | output | 1 | Modulus control: high asks the prescaler for P+1 |
| cfg_err | output | 1 | Swallow count in use exceeds main count in use |

## Verification
The bench sweeps R from 0 to 40, and every (A, B) pair with B up to 6 under both modulus pairs, checking each period length and the number of ticks spent at P+1 against P·B+A and A·(P+1). If a swallow counter were off by one, these counts would miss by one modulus step. If the final period were mishandled, the length would miss by P. The edges A = 0, A = B, A > B, R = 0 and B = 0 are covered: a design that underflows the swallow counter would stretch periods, and one that treats zero literally would stall. Ratios are also rewritten mid-period, to catch a design that applies new values at once and produces a truncated period. Gapped tick patterns are used so that tick counting is not confused with clock counting.

// File: rtl/psd_pkg.sv
package psd_pkg;
   localparam int DEF_R_W  = 15;
   localparam int DEF_A_W  = 7;
   localparam int DEF_B_W  = 11;
   localparam int DEF_P_LO = 16;
   localparam int DEF_P_HI = 32;

   typedef enum logic {
      PAIR_LOW  = 1'b0,
      PAIR_HIGH = 1'b1
   } pair_sel_e;
endpackage

// File: rtl/psd_ref_divider.sv
module psd_ref_divider #(
   parameter int R_W = psd_pkg::DEF_R_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           tick,
   input  logic [R_W-1:0] ratio,
   output logic           pulse
);
   logic [R_W-1:0] cnt;
   logic [R_W-1:0] act;
   logic [R_W-1:0] last_idx;
   logic           term;

   // a ratio of zero is treated as one
   assign last_idx = (act == '0) ? '0 : act - 1'b1;
   assign term     = (cnt == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         act   <= '0;
         pulse <= 1'b0;
      end else if (!run) begin
         cnt   <= '0;
         act   <= ratio;
         pulse <= 1'b0;
      end else begin
         pulse <= tick && term;
         if (tick) begin
            if (term) begin
               cnt <= '0;
               act <= ratio;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/psd_prescaler_model.sv
module psd_prescaler_model #(
   parameter int P_LO = psd_pkg::DEF_P_LO,
   parameter int P_HI = psd_pkg::DEF_P_HI
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic in_tick,
   input  logic hi_pair,
   input  logic mod_up,
   output logic out_tc
);
   localparam int CW = $clog2(P_HI + 2);

   logic [CW-1:0] cnt;
   logic [CW-1:0] modulus;
   logic          term;

   assign modulus = (hi_pair ? CW'(P_HI) : CW'(P_LO)) + CW'(mod_up);
   assign term    = (cnt == modulus - 1'b1);
   assign out_tc  = run && in_tick && term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (in_tick) begin
         cnt <= term ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/psd_swallow_divider.sv
module psd_swallow_divider #(
   parameter int A_W = psd_pkg::DEF_A_W,
   parameter int B_W = psd_pkg::DEF_B_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           pre_tc,
   input  logic [A_W-1:0] a_in,
   input  logic [B_W-1:0] b_in,
   input  logic           psel_in,
   output logic           mod_up,
   output logic           psel_act,
   output logic           pulse,
   output logic           cfg_err
);
   logic [A_W-1:0] sw;
   logic [B_W-1:0] mc;
   logic [A_W-1:0] a_act;
   logic [B_W-1:0] b_act;
   logic [B_W-1:0] b_last;
   logic           term;

   assign b_last  = (b_act == '0) ? '0 : b_act - 1'b1;
   assign term    = (mc == b_last);
   assign mod_up  = (sw != '0);
   assign cfg_err = (B_W'(a_act) > b_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw       <= '0;
         mc       <= '0;
         a_act    <= '0;
         b_act    <= '0;
         psel_act <= 1'b0;
         pulse    <= 1'b0;
      end else if (!run) begin
         sw       <= a_in;
         mc       <= '0;
         a_act    <= a_in;
         b_act    <= b_in;
         psel_act <= psel_in;
         pulse    <= 1'b0;
      end else begin
         pulse <= pre_tc && term;
         if (pre_tc) begin
            if (term) begin
               mc       <= '0;
               sw       <= a_in;
               a_act    <= a_in;
               b_act    <= b_in;
               psel_act <= psel_in;
            end else begin
               mc <= mc + 1'b1;
               if (sw != '0) sw <= sw - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
   parameter int R_W          = psd_pkg::DEF_R_W,
   parameter int A_W          = psd_pkg::DEF_A_W,
   parameter int B_W          = psd_pkg::DEF_B_W,
   parameter int P_LO         = psd_pkg::DEF_P_LO,
   parameter int P_HI         = psd_pkg::DEF_P_HI,
   parameter bit USE_PRESCALER_MODEL = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pll_en,
   input  logic           ref_tick,
   input  logic           lo_tick,
   input  logic [R_W-1:0] r_ratio,
   input  logic [A_W-1:0] a_count,
   input  logic [B_W-1:0] b_count,
   input  logic           pair_sel,
   output logic           ref_pulse,
   output logic           lo_pulse,
   output logic           mod_ctl,
   output logic           cfg_err
);
   generate
      if (R_W < 1 || A_W < 1 || B_W < 1) begin : g_bad_width
         $error("divider widths must be at least one bit");
      end
      if (A_W > B_W) begin : g_bad_ab
         $error("swallow counter must not be wider than main counter");
      end
      if (P_LO < 2 || P_HI <= P_LO) begin : g_bad_pair
         $error("modulus pair values must satisfy 2 <= P_LO < P_HI");
      end
   endgenerate

   logic pre_tc;
   logic psel_act;

   psd_ref_divider #(.R_W(R_W)) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (pll_en),
      .tick  (ref_tick),
      .ratio (r_ratio),
      .pulse (ref_pulse)
   );

   generate
      if (USE_PRESCALER_MODEL) begin : g_model
         psd_prescaler_model #(.P_LO(P_LO), .P_HI(P_HI)) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (pll_en),
            .in_tick (lo_tick),
            .hi_pair (psel_act),
            .mod_up  (mod_ctl),
            .out_tc  (pre_tc)
         );
      end else begin : g_external
         assign pre_tc = pll_en && lo_tick;
      end
   endgenerate

   psd_swallow_divider #(.A_W(A_W), .B_W(B_W)) u_swl (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (pll_en),
      .pre_tc   (pre_tc),
      .a_in     (a_count),
      .b_in     (b_count),
      .psel_in  (pair_sel),
      .mod_up   (mod_ctl),
      .psel_act (psel_act),
      .pulse    (lo_pulse),
      .cfg_err  (cfg_err)
   );
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
   parameter int A_W = psd_pkg::DEF_A_W,
   parameter int B_W = psd_pkg::DEF_B_W
) (
   input logic           clk,
   input logic           rst_n,
   input logic           pll_en,
   input logic           ref_tick,
   input logic           lo_tick,
   input logic [A_W-1:0] a_count,
   input logic [B_W-1:0] b_count,
   input logic           ref_pulse,
   input logic           lo_pulse,
   input logic           mod_ctl,
   input logic           cfg_err
);
   AST_REF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) // R1
      ref_pulse |-> $past(ref_tick));

   AST_LO_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) // R2
      lo_pulse |-> $past(lo_tick));

   AST_RELOAD_MODCTL: assert property (@(posedge clk) disable iff (!rst_n) // R4
      lo_pulse |-> (mod_ctl == ($past(a_count) != '0)));

   AST_CFG_ERR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) // R5
      !pll_en |=> (cfg_err == (B_W'($past(a_count)) > $past(b_count))));

   AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) // R7
      !pll_en |=> (!ref_pulse && !lo_pulse));

   always_comb begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!ref_pulse && !lo_pulse && !mod_ctl && !cfg_err); // R8
      end
   end
endmodule

bind pulse_swallow_divider psd_checker #(.A_W(A_W), .B_W(B_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pll_en    (pll_en),
   .ref_tick  (ref_tick),
   .lo_tick   (lo_tick),
   .a_count   (a_count),
   .b_count   (b_count),
   .ref_pulse (ref_pulse),
   .lo_pulse  (lo_pulse),
   .mod_ctl   (mod_ctl),
   .cfg_err   (cfg_err)
);

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pll_en = 1'b0;
   logic        ref_tick = 1'b0;
   logic        lo_tick = 1'b0;
   logic [14:0] r_ratio = '0;
   logic [6:0]  a_count = '0;
   logic [10:0] b_count = '0;
   logic        pair_sel = 1'b0;
   logic        ref_pulse, lo_pulse, mod_ctl, cfg_err;

   int total = 0;
   int bad = 0;
   bit gap_mode = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   int lo_cnt = 0, hi_cnt = 0, lo_meas = 0, hi_meas = 0, lo_seen = 0;
   int ref_cnt = 0, ref_meas = 0, ref_seen = 0;

   always #2 clk = ~clk;

   pulse_swallow_divider u_pulse_swallow_divider (
      .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .ref_tick(ref_tick),
      .lo_tick(lo_tick), .r_ratio(r_ratio), .a_count(a_count),
      .b_count(b_count), .pair_sel(pair_sel), .ref_pulse(ref_pulse),
      .lo_pulse(lo_pulse), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
   );

   // tick driver
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lo_tick  = gap_mode ? (lfsr[1:0] != 2'b00) : 1'b1;
      ref_tick = gap_mode ? (lfsr[3:2] != 2'b00) : 1'b1;
   end

   // tick counters as the design sees them
   always @(posedge clk) begin
      if (!pll_en) begin
         lo_cnt = 0; hi_cnt = 0; ref_cnt = 0;
      end else begin
         if (lo_tick) begin
            lo_cnt++;
            if (mod_ctl) hi_cnt++;
         end
         if (ref_tick) ref_cnt++;
      end
   end

   always @(negedge clk) begin
      if (lo_pulse) begin
         lo_meas = lo_cnt; hi_meas = hi_cnt;
         lo_cnt = 0; hi_cnt = 0; lo_seen++;
      end
      if (ref_pulse) begin
         ref_meas = ref_cnt; ref_cnt = 0; ref_seen++;
      end
   end

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic configure(int r, int a, int b, bit ps);
      @(negedge clk);
      pll_en = 1'b0;
      r_ratio = 15'(r); a_count = 7'(a); b_count = 11'(b); pair_sel = ps;
      repeat (3) @(negedge clk);
      pll_en = 1'b1;
   endtask

   task automatic wait_lo(string tag, int exp_len, int exp_hi);
      int prev = lo_seen;
      int waited = 0;
      while (lo_seen == prev && waited < 6000) begin
         @(posedge clk);
         waited++;
      end
      if (lo_seen == prev) begin
         check({tag, " timeout"}, 0, 1);
      end else begin
         check({tag, " length"}, lo_meas, exp_len);
         check({tag, " ticks at P+1"}, hi_meas, exp_hi);
      end
   endtask

   task automatic wait_ref(string tag, int exp_len);
      int prev = ref_seen;
      int waited = 0;
      while (ref_seen == prev && waited < 6000) begin
         @(posedge clk);
         waited++;
      end
      if (ref_seen == prev) check({tag, " timeout"}, 0, 1);
      else check(tag, ref_meas, exp_len);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int p, len, hi, before_lo, before_ref;
      // R8 reset state
      repeat (3) @(negedge clk);
      check("R8 reset outputs", {ref_pulse, lo_pulse, mod_ctl, cfg_err}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R8 after reset outputs", {ref_pulse, lo_pulse, mod_ctl, cfg_err}, 0);

      // R1 reference sweep, R = 0 acts as 1
      for (int r = 0; r <= 40; r++) begin
         configure(r, 0, 1, 1'b0);
         wait_ref($sformatf("R1 ref R=%0d first", r), (r == 0) ? 1 : r);
         wait_ref($sformatf("R1 ref R=%0d second", r), (r == 0) ? 1 : r);
      end

      // R2 R3 R4 exhaustive small sweep with A <= B
      for (int ps = 0; ps < 2; ps++) begin
         p = (ps == 0) ? 16 : 32;
         for (int b = 1; b <= 6; b++) begin
            for (int a = 0; a <= b; a++) begin
               configure(1, a, b, ps[0]);
               wait_lo($sformatf("R2 R3 R4 P=%0d A=%0d B=%0d", p, a, b),
                       p * b + a, a * (p + 1));
               check("R5 no error when A<=B", cfg_err, 0);
            end
         end
      end

      // R2 B = 0 acts as 1
      configure(1, 0, 0, 1'b1);
      wait_lo("R2 B=0 acts as 1", 32, 0);

      // R5 A > B
      configure(1, 5, 3, 1'b0);
      check("R5 cfg_err A>B", cfg_err, 1);
      wait_lo("R5 A>B period", 3 * 17, 3 * 17);
      configure(1, 3, 3, 1'b0);
      check("R5 cfg_err A=B", cfg_err, 0);
      wait_lo("R5 A=B period", 51, 51);

      // gapped ticks
      gap_mode = 1'b1;
      configure(7, 2, 5, 1'b1);
      wait_lo("R2 gapped P=32 A=2 B=5", 162, 66);
      wait_ref("R1 gapped R=7", 7);
      configure(13, 6, 6, 1'b0);
      wait_lo("R4 gapped P=16 A=6 B=6", 102, 102);
      wait_ref("R1 gapped R=13", 13);
      gap_mode = 1'b0;

      // R6 mid-period reprogramming
      configure(9, 2, 3, 1'b0);
      wait_lo("R6 old first", 50, 34);
      @(negedge clk);
      a_count = 7'd1; b_count = 11'd2; pair_sel = 1'b1;
      wait_lo("R6 old kept", 50, 34);
      wait_lo("R6 new applied", 65, 33);
      wait_ref("R6 ref old first", 9);
      @(negedge clk);
      r_ratio = 15'd20;
      wait_ref("R6 ref old kept", 9);
      wait_ref("R6 ref new applied", 20);

      // R7 disabled: no pulses, then full first period
      @(negedge clk);
      pll_en = 1'b0;
      before_lo = lo_seen; before_ref = ref_seen;
      repeat (200) @(negedge clk);
      check("R7 no lo pulse while disabled", lo_seen - before_lo, 0);
      check("R7 no ref pulse while disabled", ref_seen - before_ref, 0);
      a_count = 7'd3; b_count = 11'd4; pair_sel = 1'b0;
      @(negedge clk);
      pll_en = 1'b1;
      wait_lo("R7 full first period", 67, 51);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule